// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers single-cycle event pulses from a network controller datapath into an 8-bit status word. A 7-bit enable mask filters those bits onto one active-high interrupt line. Seven sources are covered:

- packet received without error
- packet transmitted without error
- receive error
- transmit error
- receive ring overwrite
- tally counter overflow
- remote DMA completion

Counter overflow comes from level inputs carrying the top bit of each network tally counter. The block turns a rise of any of them into an event.

The eighth status bit is not an event latch. It is a level flag that shows whether the controller is offline. Entering the reset state or a ring overwrite sets it. A start command or the removal of packets from the ring clears it. The host cannot write it, and it never raises the interrupt.

The host reaches the block through a one-bit-address register port. Address 0 selects the status word, which the host clears by writing ones. Address 1 selects the mask. Reads are combinational from the addressed register.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word reads 0x80, the mask reads 0x00 and `irq_o` is low.
- R2: Status bit positions are: 0 rx ok, 1 tx ok, 2 rx error, 3 tx error, 4 ring overwrite, 5 counter overflow, 6 DMA done. A pulse on a source sets its bit at the next clock edge, and the bit holds until the host clears it.
- R3: Status bit 5 sets on the edge after any `tally_msb_i` bit goes from 0 to 1. A counter top bit that stays high does not set it again after a clear.
- R4: A write to address 0 clears each of bits 6:0 whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R5: If a source pulse and a host clear hit the same bit in one cycle, the bit ends up set.
- R6: A write to address 1 stores write-data bits 6:0 as the mask. Mask bit 7 always reads 0.
- R7: `irq_o` is high exactly when some status bit in 6:0 and the same mask bit are both 1.
- R8: Status bit 7 sets on `enter_reset_i` or `ring_ovw_i` and clears on `start_cmd_i` or `pkt_removed_i`. A set and a clear in the same cycle leave it set.
- R9: Status bit 7 ignores host writes and never drives `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_ok_i | input | 1 | Packet received pulse |
| tx_ok_i | input | 1 | Packet transmitted pulse |
| rx_err_i | input | 1 | Receive error pulse |
| tx_err_i | input | 1 | Transmit error pulse |
| ring_ovw_i | input | 1 | Receive ring overwrite pulse |
| dma_done_i | input | 1 | Remote DMA complete pulse |
| tally_msb_i | input | NUM_TALLY | Top bit of each tally counter (level) |
| enter_reset_i | input | 1 | Controller entering offline state (pulse) |
| start_cmd_i | input | 1 | Start command issued (pulse) |
| pkt_removed_i | input | 1 | Packet(s) removed from the ring (pulse) |
| reg_we_i | input | 1 | Host write strobe |
| reg_addr_i | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A vector table walks the status word through single pulses, pulses on two sources at once, partial clears with selective masks, and a pulse that coincides with its own clear.

- The table separates per-bit latching from mask gating, because some steps hold pending bits while the mask is zero and others hold masked-off bits alongside enabled ones.
- Directed tests hold a tally top bit high across a clear. This shows the block reacts to rises rather than to levels.
- Further directed tests drive each set and clear cause of the offline flag alone and then together. They also write ones at bit 7 and enable every mask bit to show that the flag never reaches the interrupt.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_W  = 7;
  localparam int STAT_W = SRC_W + 1;

  localparam int B_RX_OK    = 0;
  localparam int B_TX_OK    = 1;
  localparam int B_RX_ERR   = 2;
  localparam int B_TX_ERR   = 3;
  localparam int B_RING_OVW = 4;
  localparam int B_CNT_OVF  = 5;
  localparam int B_DMA_DONE = 6;
  localparam int B_OFFLINE  = 7;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic         any_rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign any_rise_o = |(lvl_i & ~lvl_q);
endmodule

// File: rtl/irq_w1c_bits.sv
module irq_w1c_bits #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;   // event beats host clear
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end

  assign q_o = q;

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  a_r4_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i == '0) && (clr_i == '0)) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/irq_offline_flag.sv
module irq_offline_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // controller comes out of reset offline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b1;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  a_r8_flag_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_TALLY = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_ok_i,
  input  logic                 tx_ok_i,
  input  logic                 rx_err_i,
  input  logic                 tx_err_i,
  input  logic                 ring_ovw_i,
  input  logic                 dma_done_i,
  input  logic [NUM_TALLY-1:0] tally_msb_i,
  input  logic                 enter_reset_i,
  input  logic                 start_cmd_i,
  input  logic                 pkt_removed_i,
  input  logic                 reg_we_i,
  input  logic                 reg_addr_i,
  input  logic [STAT_W-1:0]    reg_wdata_i,
  output logic [STAT_W-1:0]    reg_rdata_o,
  output logic                 irq_o
);
  logic              cnt_ovf_evt;
  logic [SRC_W-1:0]  src_evt;
  logic [SRC_W-1:0]  host_clr;
  logic [SRC_W-1:0]  status_q;
  logic [SRC_W-1:0]  mask_q;
  logic              offline;
  logic              wr_status;
  logic              wr_mask;
  logic              flag_set;
  logic              flag_clr;

  irq_rise_detect #(.N(NUM_TALLY)) u_rise (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (tally_msb_i),
    .any_rise_o (cnt_ovf_evt)
  );

  always_comb begin
    src_evt             = '0;
    src_evt[B_RX_OK]    = rx_ok_i;
    src_evt[B_TX_OK]    = tx_ok_i;
    src_evt[B_RX_ERR]   = rx_err_i;
    src_evt[B_TX_ERR]   = tx_err_i;
    src_evt[B_RING_OVW] = ring_ovw_i;
    src_evt[B_CNT_OVF]  = cnt_ovf_evt;
    src_evt[B_DMA_DONE] = dma_done_i;
  end

  assign wr_status = reg_we_i && (reg_addr_i == SEL_STATUS);
  assign wr_mask   = reg_we_i && (reg_addr_i == SEL_MASK);
  assign host_clr  = wr_status ? reg_wdata_i[SRC_W-1:0] : '0;

  irq_w1c_bits #(.W(SRC_W)) u_bits (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_evt),
    .clr_i  (host_clr),
    .q_o    (status_q)
  );

  assign flag_set = enter_reset_i || ring_ovw_i;
  assign flag_clr = start_cmd_i || pkt_removed_i;

  irq_offline_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (offline)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata_i[SRC_W-1:0];
  end

  always_comb begin
    if (reg_addr_i == SEL_MASK) reg_rdata_o = {1'b0, mask_q};
    else                        reg_rdata_o = {offline, status_q};
  end

  assign irq_o = |(status_q & mask_q);

  a_r3_tally_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(tally_msb_i & ~$past(tally_msb_i))) |=> status_q[B_CNT_OVF]);

  a_r9_flag_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == '0) |-> !irq_o);

  a_r9_flag_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && reg_wdata_i[B_OFFLINE] && !flag_set && !flag_clr) |=> $stable(offline));

  a_r6_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  localparam int NT = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rx_ok_i = 0, tx_ok_i = 0, rx_err_i = 0, tx_err_i = 0;
  logic          ring_ovw_i = 0, dma_done_i = 0;
  logic [NT-1:0] tally_msb_i = '0;
  logic          enter_reset_i = 0, start_cmd_i = 0, pkt_removed_i = 0;
  logic          reg_we_i = 0, reg_addr_i = 0;
  logic [7:0]    reg_wdata_i = '0;
  logic [7:0]    reg_rdata_o;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;   // 125 MHz

  irq_status_ctrl #(.NUM_TALLY(NT)) u0 (
    .clk_i, .rst_ni, .rx_ok_i, .tx_ok_i, .rx_err_i, .tx_err_i,
    .ring_ovw_i, .dma_done_i, .tally_msb_i, .enter_reset_i,
    .start_cmd_i, .pkt_removed_i, .reg_we_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  typedef struct packed {
    logic [6:0] pulse;
    logic [6:0] clr;
    logic [6:0] mask;
    logic [6:0] exp_st;
    logic       exp_irq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{7'h01, 7'h00, 7'h00, 7'h01, 1'b0},
    '{7'h02, 7'h00, 7'h01, 7'h03, 1'b1},
    '{7'h00, 7'h01, 7'h01, 7'h02, 1'b0},
    '{7'h0C, 7'h02, 7'h08, 7'h0C, 1'b1},
    '{7'h10, 7'h0C, 7'h10, 7'h10, 1'b1},
    '{7'h20, 7'h00, 7'h00, 7'h30, 1'b0},
    '{7'h40, 7'h10, 7'h40, 7'h60, 1'b1},
    '{7'h01, 7'h01, 7'h00, 7'h61, 1'b0},
    '{7'h00, 7'h7F, 7'h7F, 7'h00, 1'b0}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_we_i = 0;
    {rx_ok_i, tx_ok_i, rx_err_i, tx_err_i, ring_ovw_i, dma_done_i} = '0;
    {enter_reset_i, start_cmd_i, pkt_removed_i} = '0;
  endtask

  // drive at negedge, let one posedge pass, return at the next negedge
  task automatic cycle();
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    cycle();
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    // R1: reset values, checked while reset is still asserted
    rd(1'b0, r); check("R1 status", r, 8'h80);
    rd(1'b1, r); check("R1 mask", r, 8'h00);
    check("R1 irq", {7'h0, irq_o}, 8'h00);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 R4 R5 R7 through the vector table
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, {1'b0, VECS[i].mask});
      {dma_done_i, ring_ovw_i, tx_err_i, rx_err_i, tx_ok_i, rx_ok_i} =
        {VECS[i].pulse[6], VECS[i].pulse[4:0]};
      tally_msb_i[0] = VECS[i].pulse[5];
      if (VECS[i].clr != '0) begin
        reg_we_i = 1; reg_addr_i = 1'b0; reg_wdata_i = {1'b0, VECS[i].clr};
      end
      cycle();
      tally_msb_i[0] = 1'b0;
      rd(1'b0, r);
      check("R2/R4/R5 status", {1'b0, r[6:0]}, {1'b0, VECS[i].exp_st});
      check("R7 irq", {7'h0, irq_o}, {7'h0, VECS[i].exp_irq});
    end

    // R6: reserved mask bit reads zero
    wr(1'b1, 8'hFF);
    rd(1'b1, r); check("R6 mask", r, 8'h7F);

    // R9: flag set, all mask bits on, no pending events -> no interrupt
    enter_reset_i = 1; cycle();
    rd(1'b0, r); check("R9 flag only", r, 8'h80);
    check("R9 irq", {7'h0, irq_o}, 8'h00);
    wr(1'b0, 8'h80);
    rd(1'b0, r); check("R9 write ignored", r, 8'h80);

    // R8: clear and set causes
    start_cmd_i = 1; cycle();
    rd(1'b0, r); check("R8 start clears", r, 8'h00);
    ring_ovw_i = 1; cycle();
    rd(1'b0, r); check("R8 overwrite sets", r, 8'h90);
    pkt_removed_i = 1; cycle();
    rd(1'b0, r); check("R8 removal clears", r, 8'h10);
    wr(1'b0, 8'h10);
    enter_reset_i = 1; cycle();
    rd(1'b0, r); check("R8 enter sets", r, 8'h80);
    start_cmd_i = 1; cycle();
    enter_reset_i = 1; start_cmd_i = 1; cycle();
    rd(1'b0, r); check("R8 set wins", r, 8'h80);

    // R3: rise detection on tally top bits
    wr(1'b1, 8'h20);
    tally_msb_i[1] = 1; cycle();
    rd(1'b0, r); check("R3 rise sets", r, 8'hA0);
    check("R3 irq", {7'h0, irq_o}, 8'h01);
    wr(1'b0, 8'h20);
    cycle();
    rd(1'b0, r); check("R3 level no retrigger", r, 8'h80);
    tally_msb_i[2] = 1; cycle();
    rd(1'b0, r); check("R3 second counter", r, 8'hA0);
    tally_msb_i = '0;

    // R4: writing zeros leaves bits set
    rx_ok_i = 1; cycle();
    wr(1'b0, 8'h00);
    rd(1'b0, r); check("R4 zero write", r, 8'hA1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule